// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges seven reset causes into one synchronous, active-high system reset. The asynchronous active-low input `rst_ni` is the power-on cause. The other six causes are watchdog overflow, an active-low external reset pin, a software request, low-voltage detect, overflow of the CPU-activity counter and clock-failure detect. Only power-on applies an oscillator settling interval: reset stays on for `POR_CYCLES` clock cycles, which is 2^16 by default. Each of the other causes gives a short stretched pulse of at least `MIN_HOLD` cycles.

The block also holds three pieces of state for the CPU. The first is a 2-bit settling-time select field, which every reset cause forces to binary 11 and which software may write only while no reset is active. The second is a set of sticky cause flags, cleared by a read-with-clear strobe. The third is a software reset bit that reads back as 1 when idle.

Top module: `reset_hub`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o`=1, `flags_o`=7'b0000001, `wsel_o`=2'b11 and `sw_bit_o`=1. After `rst_ni` rises, `sys_rst_o` stays 1 through the first `POR_CYCLES` rising edges and drops on the next one.
- R2: A watchdog, software, low-voltage, CPU-activity or clock-failure request seen at a rising edge asserts `sys_rst_o` after that edge, with no settling wait.
- R3: `sys_rst_o` stays 1 for `MIN_HOLD` cycles after the edge that captures the last non-power-on request. A request that arrives while reset is active restarts this count.
- R4: The external pin `ext_rst_ni` passes through two synchronizer flops. A low level first asserts `sys_rst_o` after the third rising edge.
- R5: A write strobe `sw_wr_i` with data 0 requests a software reset. A write of 1 has no effect on `sys_rst_o` or on the flags.
- R6: `sw_bit_o` reads 1 when idle. It reads 0 from the edge that captures a software request until the edge after `sys_rst_o` is released.
- R7: Any reset cause sets `wsel_o` to 2'b11.
- R8: `wsel_we_i` loads `wsel_wdata_i` only while `sys_rst_o` is 0. A write during reset is ignored.
- R9: Each cause sets its own sticky bit in `flags_o`: bit0 power-on, bit1 watchdog, bit2 external, bit3 software, bit4 low-voltage, bit5 CPU-activity, bit6 clock failure.
- R10: `flag_rd_i` clears all flags on the next edge. A request captured on the same edge still sets its bit.
- R11: A power-on clears every flag except bit0. Asserting `rst_ni` again while the settling count runs restarts that count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| wdt_ovf_i | input | 1 | Watchdog overflow request |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| sw_wr_i | input | 1 | Write strobe for the software reset bit |
| sw_wdata_i | input | 1 | Write data for the software reset bit (0 requests reset) |
| lvd_i | input | 1 | Low-voltage detect request |
| cpu_ovf_i | input | 1 | CPU-activity counter overflow request |
| clk_fail_i | input | 1 | Clock-failure detect request |
| wsel_we_i | input | 1 | Write strobe for the settling-time select field |
| wsel_wdata_i | input | 2 | Write data for the settling-time select field |
| flag_rd_i | input | 1 | Read-with-clear strobe for the cause flags |
| sys_rst_o | output | 1 | System reset, active high, synchronous release |
| wsel_o | output | 2 | Settling-time select field |
| flags_o | output | 7 | Sticky reset cause flags |
| sw_bit_o | output | 1 | Software reset bit read-back |

## Verification
The latencies differ by cause:
- An internal request driven before an edge shows on `sys_rst_o` and on the flags and select field right after that edge.
- The external pin takes two more edges.
- Power-on holds for exactly `POR_CYCLES` sampled cycles.
- `sw_bit_o` returns to 1 one cycle after release.

The bench drives on the falling edge and samples on the falling edge that follows the edge it computes for each result. It counts consecutive high samples of `sys_rst_o` and compares them against `MIN_HOLD` or `POR_CYCLES` exactly. That exact count also catches a missing restart when a second request arrives.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int NUM_CAUSES = 7;
  typedef enum int {
    C_POR = 0,
    C_WDT = 1,
    C_EXT = 2,
    C_SW  = 3,
    C_LVD = 4,
    C_CPU = 5,
    C_CLK = 6
  } cause_e;
endpackage

// File: rtl/rh_sync.sv
module rh_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= {STAGES{RST_VAL}};
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/rh_por_timer.sv
module rh_por_timer #(
  parameter int CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CW'(CYCLES)) busy_q <= 1'b0;
      else                      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/rh_hold.sv
module rh_hold #(
  parameter int HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] cnt_q;

  // retrigger reloads the full count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (trig_i)       cnt_q <= HW'(HOLD);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int         POR_CYCLES = 65536,
  parameter int         MIN_HOLD   = 4,
  parameter logic [1:0] WSEL_RST   = 2'b11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wdt_ovf_i,
  input  logic                  ext_rst_ni,
  input  logic                  sw_wr_i,
  input  logic                  sw_wdata_i,
  input  logic                  lvd_i,
  input  logic                  cpu_ovf_i,
  input  logic                  clk_fail_i,
  input  logic                  wsel_we_i,
  input  logic [1:0]            wsel_wdata_i,
  input  logic                  flag_rd_i,
  output logic                  sys_rst_o,
  output logic [1:0]            wsel_o,
  output logic [NUM_CAUSES-1:0] flags_o,
  output logic                  sw_bit_o
);
  logic                  ext_sync;
  logic [NUM_CAUSES-1:0] req_vec;
  logic                  req_any;
  logic                  por_busy;
  logic                  hold_act;
  logic [NUM_CAUSES-1:0] flags_q;
  logic [1:0]            wsel_q;
  logic                  sw_pend_q;

  rh_sync #(.STAGES(2), .RST_VAL(1'b1)) u_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_rst_ni),
    .q_o    (ext_sync)
  );

  always_comb begin
    req_vec        = '0;
    req_vec[C_WDT] = wdt_ovf_i;
    req_vec[C_EXT] = ~ext_sync;
    req_vec[C_SW]  = sw_wr_i & ~sw_wdata_i;
    req_vec[C_LVD] = lvd_i;
    req_vec[C_CPU] = cpu_ovf_i;
    req_vec[C_CLK] = clk_fail_i;
  end

  assign req_any = |req_vec;

  rh_por_timer #(.CYCLES(POR_CYCLES)) u_por (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_o (por_busy)
  );

  rh_hold #(.HOLD(MIN_HOLD)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (req_any),
    .active_o (hold_act)
  );

  assign sys_rst_o = por_busy | hold_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q        <= '0;
      flags_q[C_POR] <= 1'b1;
    end else begin
      flags_q <= (flag_rd_i ? '0 : flags_q) | req_vec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      wsel_q <= WSEL_RST;
    else if (req_any)                 wsel_q <= WSEL_RST;
    else if (wsel_we_i && !sys_rst_o) wsel_q <= wsel_wdata_i;
  end

  // pending until the cycle after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             sw_pend_q <= 1'b0;
    else if (req_vec[C_SW])  sw_pend_q <= 1'b1;
    else if (!sys_rst_o)     sw_pend_q <= 1'b0;
  end

  assign wsel_o   = wsel_q;
  assign flags_o  = flags_q;
  assign sw_bit_o = ~sw_pend_q;
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk
  import reset_hub_pkg::*;
#(
  parameter int MIN_HOLD = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_CAUSES-1:0] req_i,
  input logic                  sys_rst_o,
  input logic [1:0]            wsel_o,
  input logic [NUM_CAUSES-1:0] flags_o,
  input logic                  sw_bit_o
);
  logic [31:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        since_q <= 32'(MIN_HOLD);
    else if (|req_i)                    since_q <= '0;
    else if (since_q < 32'(MIN_HOLD))   since_q <= since_q + 1'b1;
  end

  p_req_asserts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |req_i |=> sys_rst_o);

  p_min_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> since_q >= 32'(MIN_HOLD));

  p_sw_bit_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[C_SW] |=> !sw_bit_o);

  p_wsel_forced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |req_i |=> wsel_o == 2'b11);

  p_wsel_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && !(|req_i)) |=> $stable(wsel_o));

  p_flag_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |req_i |=> ((flags_o & $past(req_i)) == $past(req_i)));
endmodule

bind reset_hub reset_hub_chk #(.MIN_HOLD(MIN_HOLD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_vec),
  .sys_rst_o (sys_rst_o),
  .wsel_o    (wsel_o),
  .flags_o   (flags_o),
  .sw_bit_o  (sw_bit_o)
);

// File: tb/reset_hub_test.sv
module reset_hub_test;
  localparam int POR_N  = 300;
  localparam int HOLD_N = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wdt_ovf_i = 1'b0, ext_rst_ni = 1'b1, sw_wr_i = 1'b0, sw_wdata_i = 1'b1;
  logic       lvd_i = 1'b0, cpu_ovf_i = 1'b0, clk_fail_i = 1'b0;
  logic       wsel_we_i = 1'b0, flag_rd_i = 1'b0;
  logic [1:0] wsel_wdata_i = 2'b00;
  logic       sys_rst_o, sw_bit_o;
  logic [1:0] wsel_o;
  logic [6:0] flags_o;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  reset_hub #(.POR_CYCLES(POR_N), .MIN_HOLD(HOLD_N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wdt_ovf_i(wdt_ovf_i), .ext_rst_ni(ext_rst_ni),
    .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i), .lvd_i(lvd_i), .cpu_ovf_i(cpu_ovf_i),
    .clk_fail_i(clk_fail_i), .wsel_we_i(wsel_we_i), .wsel_wdata_i(wsel_wdata_i),
    .flag_rd_i(flag_rd_i), .sys_rst_o(sys_rst_o), .wsel_o(wsel_o), .flags_o(flags_o),
    .sw_bit_o(sw_bit_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (sys_rst_o && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk) flag_rd_i = 1'b1;
    @(negedge clk) flag_rd_i = 1'b0;
  endtask

  task automatic drive_cause(input int b, input logic v);
    case (b)
      1: wdt_ovf_i = v;
      2: ext_rst_ni = ~v;
      3: begin sw_wr_i = v; sw_wdata_i = ~v; end
      4: lvd_i = v;
      5: cpu_ovf_i = v;
      default: clk_fail_i = v;
    endcase
  endtask

  // R1, R11: power-on values and settling count
  task automatic t_power_on();
    int n;
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", "sys_rst in por", sys_rst_o, 1);
    chk("R1", "flags in por", flags_o, 1);
    chk("R1", "wsel in por", wsel_o, 3);
    chk("R1", "sw_bit in por", sw_bit_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    count_high(n);
    chk("R1", "por hold cycles", n, POR_N);
    chk("R1", "por flag kept", flags_o, 1);
  endtask

  // R2, R3, R4, R9, R7: each non-por cause alone
  task automatic t_cause(input int b);
    int n;
    clear_flags();
    drive_cause(b, 1'b1);
    @(negedge clk) drive_cause(b, 1'b0);
    if (b == 2) begin
      chk("R4", "ext not yet in reset", sys_rst_o, 0);
      @(negedge clk);
      chk("R4", "ext still synchronizing", sys_rst_o, 0);
      @(negedge clk);
    end
    chk("R2", $sformatf("cause %0d immediate", b), sys_rst_o, 1);
    count_high(n);
    chk("R3", $sformatf("cause %0d hold", b), n, HOLD_N);
    chk("R9", $sformatf("cause %0d flag", b), flags_o, 1 << b);
    chk("R7", $sformatf("cause %0d wsel", b), wsel_o, 3);
  endtask

  // R3: retrigger during active reset
  task automatic t_restart();
    int n;
    @(negedge clk) wdt_ovf_i = 1'b1;
    @(negedge clk) wdt_ovf_i = 1'b0;
    @(negedge clk) lvd_i = 1'b1;
    @(negedge clk) lvd_i = 1'b0;
    count_high(n);
    chk("R3", "restarted hold remaining", n, HOLD_N);
  endtask

  // R7, R8: select field writes
  task automatic t_wsel();
    int n;
    @(negedge clk) begin wsel_we_i = 1'b1; wsel_wdata_i = 2'b01; end
    @(negedge clk) wsel_we_i = 1'b0;
    chk("R8", "wsel idle write", wsel_o, 1);
    wdt_ovf_i = 1'b1;
    @(negedge clk) begin wdt_ovf_i = 1'b0; wsel_we_i = 1'b1; wsel_wdata_i = 2'b10; end
    @(negedge clk) wsel_we_i = 1'b0;
    chk("R8", "wsel write in reset ignored", wsel_o, 3);
    count_high(n);
    chk("R7", "wsel after wdt", wsel_o, 3);
    wsel_we_i = 1'b1; wsel_wdata_i = 2'b00;
    @(negedge clk) wsel_we_i = 1'b0;
    chk("R8", "wsel write 00", wsel_o, 0);
    cpu_ovf_i = 1'b1;
    @(negedge clk) cpu_ovf_i = 1'b0;
    count_high(n);
    chk("R7", "wsel forced by cpu cause", wsel_o, 3);
  endtask

  // R5, R6: software bit
  task automatic t_soft();
    int n;
    clear_flags();
    sw_wr_i = 1'b1; sw_wdata_i = 1'b1;
    @(negedge clk) sw_wr_i = 1'b0;
    chk("R5", "write 1 no reset", sys_rst_o, 0);
    chk("R5", "write 1 no flag", flags_o, 0);
    chk("R6", "sw_bit idle", sw_bit_o, 1);
    sw_wr_i = 1'b1; sw_wdata_i = 1'b0;
    @(negedge clk) begin sw_wr_i = 1'b0; sw_wdata_i = 1'b1; end
    chk("R5", "write 0 resets", sys_rst_o, 1);
    chk("R6", "sw_bit during reset", sw_bit_o, 0);
    count_high(n);
    chk("R6", "sw_bit at release", sw_bit_o, 0);
    @(negedge clk);
    chk("R6", "sw_bit after release", sw_bit_o, 1);
  endtask

  // R10: clear and concurrent set
  task automatic t_clear_race();
    int n;
    @(negedge clk) wdt_ovf_i = 1'b1;
    @(negedge clk) wdt_ovf_i = 1'b0;
    count_high(n);
    flag_rd_i = 1'b1; lvd_i = 1'b1;
    @(negedge clk) begin flag_rd_i = 1'b0; lvd_i = 1'b0; end
    chk("R10", "set wins over clear", flags_o, 1 << 4);
    count_high(n);
    clear_flags();
    chk("R10", "clear empties", flags_o, 0);
  endtask

  // R11: por clears flags and restarts count
  task automatic t_por_again();
    int n;
    @(negedge clk) clk_fail_i = 1'b1;
    @(negedge clk) clk_fail_i = 1'b0;
    chk("R9", "clk fail flag set", flags_o, 1 << 6);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R11", "por clears other flags", flags_o, 1);
    rst_ni = 1'b1;
    repeat (50) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    count_high(n);
    chk("R11", "por count restarted", n, POR_N);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_power_on();
    for (int b = 1; b < 7; b++) t_cause(b);
    t_restart();
    t_wsel();
    t_soft();
    t_clear_race();
    t_por_again();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule